// File: doc/BRIEF.md
# Threshold-Adapting Bandwidth Governor

This block services a bandwidth monitor's interrupt in hardware so that no processor has to. When the monitor raises its interrupt, the governor reads the monitor's status register. It ignores the event if neither of the two zones it cares about has fired. Otherwise it shuts the monitor down and reads the peak count of the zone that fired. It turns that count into a bandwidth figure in kB/s and snaps the figure to one of five fixed performance levels.

Around the chosen level it writes a new pair of thresholds, an upper one and a lower one. This forms a hysteresis band, so the next interrupt only arrives when traffic leaves the band. It then re-arms the monitor with a zone enable mask that depends on where the level sits in the table. Whenever the chosen level changes, the new level index is sent out with a one-cycle strobe, and a downstream voter acts on it. After reset the governor first writes the monitor's start-up configuration.

The monitor is reached through a simple register master port. A read returns data in the cycle after the request, and a write takes one cycle.

Top module: `bw_governor`

## Requirements
- R1: While reset is held there is no bus request and no level strobe. After reset the governor writes exactly these fifteen (address, value) pairs, in this order, and then goes idle:
  - 0x01 ← 0, 0x0A ← 0, 0x10 ← 0, 0x11 ← 1
  - sample window 0x12 ← 76800
  - upper threshold 0x13 ← 307, lower threshold 0x14 ← 32, floor threshold 0x15 ← 0
  - hit counts 0x16 ← 0x01FF10FF
  - zone actions 0x17 ← 0x95250901
  - 0x09 ← 0xA0, 0x02 ← 1, 0x01 ← 1, 0x0A ← 0xA0, 0x10 ← 1
- R2: When the interrupt is seen while idle, the governor reads the status register at 0x08. If that value ANDed with 0xA0 is zero, the event is dropped: no further bus activity and no level output.
- R3: The fired zone is zone 3 when status bit 7 is set, and zone 1 otherwise (bit 5). Its peak count is read from address 0x18 plus the zone number.
- R4: Before the peak read, the governor writes 0 to the global interrupt enable (0x01), then 0 to the local zone enable (0x0A), then 0 to the monitor enable (0x10).
- R5: The measured bandwidth is (peak+1)×16000 kB/s. The target is the smallest level in {4800000, 9216000, 15052800, 20889600, 25497600} that is at or above the measurement, with indices 0 to 4. Above all five levels, index 4 is used.
- R6: A bandwidth b is written as a threshold value of floor(floor(b/64)×4/1000). The first re-arm write puts the value for target+1 into 0x13.
- R7: The second re-arm write puts the threshold for the next lower level into 0x14. At index 0 it uses the target level itself.
- R8: The local enable written on re-arm is 0x20 (zone 1 only) at index 4, 0x80 (zone 3 only) at index 0, and 0xA0 otherwise. No bit outside 0xA0 is ever set.
- R9: The re-arm order is: the two thresholds, then counter clear 0x11 ← 1, local clear 0x09 ← 0xA0, global clear 0x02 ← 1, global enable 0x01 ← 1, local enable 0x0A, and monitor enable 0x10 ← 1.
- R10: A one-cycle strobe with the target index is given when no level has been output since reset, or when the target differs from the last output level. Otherwise no strobe is given.
- R11: The interrupt input is ignored while busy, that is, from the start-up writes until the last re-arm write of a serviced event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Monitor interrupt, level |
| rg_en | output | 1 | Bus request this cycle |
| rg_wr | output | 1 | 1 = write, 0 = read |
| rg_addr | output | 6 | Register word address |
| rg_wdata | output | 32 | Write data (0 on reads) |
| rg_rdata | input | 32 | Read data, valid the cycle after a read request |
| lvl_idx | output | 3 | Last selected level index |
| lvl_vld | output | 1 | One-cycle strobe when a new level is selected |
| busy | output | 1 | High while the governor is writing or servicing |

## Verification
The assertions take for granted that read data arrives exactly one cycle after a read request, and that the monitor answers every request with no wait states. The bench's register model answers in exactly that way. They also take the peak count as a 32-bit value whose bandwidth product fits in 64 bits. Stimulus keeps peaks below a few thousand and holds the interrupt for one cycle per event. The only exception is a deliberate second pulse sent while busy.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
    parameter int DW        = 32;
    parameter int AW        = 6;
    parameter int NLVL      = 5;
    parameter int SAMPLE_MS = 4;
    parameter int TIMER_HZ  = 19200000;
    parameter int UNIT_KB   = 64;
    parameter int Z1_HITS   = 16;
    parameter int Z3_HITS   = 1;

    localparam int LW = $clog2(NLVL);
    localparam int ST_ZONE_LSB = 4;
    localparam logic [7:0] ZEN1     = 8'h20;
    localparam logic [7:0] ZEN3     = 8'h80;
    localparam logic [7:0] ZEN_BOTH = ZEN1 | ZEN3;

    localparam logic [AW-1:0] A_GEN   = AW'(8'h01);
    localparam logic [AW-1:0] A_GCLR  = AW'(8'h02);
    localparam logic [AW-1:0] A_ISTAT = AW'(8'h08);
    localparam logic [AW-1:0] A_ICLR  = AW'(8'h09);
    localparam logic [AW-1:0] A_IEN   = AW'(8'h0A);
    localparam logic [AW-1:0] A_MEN   = AW'(8'h10);
    localparam logic [AW-1:0] A_CCLR  = AW'(8'h11);
    localparam logic [AW-1:0] A_WIN   = AW'(8'h12);
    localparam logic [AW-1:0] A_THI   = AW'(8'h13);
    localparam logic [AW-1:0] A_TMD   = AW'(8'h14);
    localparam logic [AW-1:0] A_TLO   = AW'(8'h15);
    localparam logic [AW-1:0] A_TCNT  = AW'(8'h16);
    localparam logic [AW-1:0] A_ZACT  = AW'(8'h17);
    localparam logic [AW-1:0] A_ZMAX0 = AW'(8'h18);

    localparam int INIT_N = 15;
    localparam int OFF_N  = 3;
    localparam int ARM_N  = 8;

    function automatic logic [63:0] lvl_kbps(input int i);
        case (i)
            0:       return 64'd4800000;
            1:       return 64'd9216000;
            2:       return 64'd15052800;
            3:       return 64'd20889600;
            default: return 64'd25497600;
        endcase
    endfunction

    function automatic logic [DW-1:0] kbps_to_thr(input logic [63:0] k);
        logic [63:0] t;
        t = ((k / 64'(UNIT_KB)) * 64'(SAMPLE_MS)) / 64'd1000;
        return t[DW-1:0];
    endfunction

    // Per-zone action byte: bump own counter (zones above 0), clear all below.
    function automatic logic [31:0] zone_actions();
        logic [31:0] v;
        logic [7:0]  b;
        v = '0;
        for (int z = 0; z < 4; z++) begin
            b = (z == 0) ? 8'h01 : 8'(2 << (2 * z));
            for (int j = 0; j < z; j++) b = b | 8'(1 << (2 * j));
            v[8*z +: 8] = b;
        end
        return v;
    endfunction

    localparam logic [DW-1:0] WIN_VAL  = DW'(SAMPLE_MS * (TIMER_HZ / 1000));
    localparam logic [DW-1:0] INIT_HI  = kbps_to_thr(64'(4800 * 1024));
    localparam logic [DW-1:0] INIT_MD  = kbps_to_thr(64'(512 * 1024));
    localparam logic [DW-1:0] TCNT_VAL = {8'(Z3_HITS), 8'hFF, 8'(Z1_HITS), 8'hFF};
    localparam logic [DW-1:0] ZACT_VAL = zone_actions();

    typedef enum logic [3:0] {
        S_RST, S_INIT, S_IDLE, S_RDST, S_WTST, S_OFF, S_RDPK, S_WTPK, S_ARM
    } seq_st_e;

    typedef struct packed {
        logic          en;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic [LW-1:0] idx;
        logic [DW-1:0] thr_hi;
        logic [DW-1:0] thr_md;
        logic [7:0]    zen;
    } plan_t;
endpackage

// File: rtl/bwg_calc.sv
module bwg_calc
    import bwg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] peak,
    output plan_t         plan
);
    logic [63:0]     meas;
    logic [NLVL-1:0] fits;
    logic [LW-1:0]   idx;
    logic [63:0]     tgt_k;
    logic [63:0]     low_k;

    assign meas = ((64'(peak) + 64'd1) * 64'(UNIT_KB) * 64'd1000) / 64'(SAMPLE_MS);

    for (genvar g = 0; g < NLVL; g++) begin : g_cmp
        assign fits[g] = (lvl_kbps(g) >= meas);
    end

    always_comb begin
        idx = LW'(NLVL - 1);
        for (int i = NLVL - 1; i >= 0; i--)
            if (fits[i]) idx = LW'(i);
    end

    assign tgt_k = lvl_kbps(int'(idx));
    assign low_k = (idx == '0) ? tgt_k : lvl_kbps(int'(idx) - 1);

    always_comb begin
        plan.idx    = idx;
        plan.thr_hi = kbps_to_thr(tgt_k + 64'd1);
        plan.thr_md = kbps_to_thr(low_k);
        if (idx == LW'(NLVL - 1))  plan.zen = ZEN1;
        else if (idx == '0)        plan.zen = ZEN3;
        else                       plan.zen = ZEN_BOTH;
    end

    assert_thr_order_R7: assert property (@(posedge clk) disable iff (rst)
        plan.thr_hi >= plan.thr_md);
    assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (meas > lvl_kbps(NLVL - 1)) |-> (plan.idx == LW'(NLVL - 1)));
endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
    import bwg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  logic [DW-1:0] rdata,
    input  plan_t         plan,
    output logic [DW-1:0] peak,
    output bus_op_t       op,
    output logic [LW-1:0] lvl_idx,
    output logic          lvl_vld,
    output logic          busy
);
    seq_st_e       st;
    logic [3:0]    step;
    logic          zone3;
    logic          have;

    function automatic bus_op_t wop(input logic [AW-1:0] a, input logic [DW-1:0] d);
        return '{en: 1'b1, wr: 1'b1, addr: a, data: d};
    endfunction
    function automatic bus_op_t rop(input logic [AW-1:0] a);
        return '{en: 1'b1, wr: 1'b0, addr: a, data: '0};
    endfunction

    always_comb begin
        op = '0;
        case (st)
            S_INIT: case (step)
                4'd0:  op = wop(A_GEN, '0);
                4'd1:  op = wop(A_IEN, '0);
                4'd2:  op = wop(A_MEN, '0);
                4'd3:  op = wop(A_CCLR, DW'(1));
                4'd4:  op = wop(A_WIN, WIN_VAL);
                4'd5:  op = wop(A_THI, INIT_HI);
                4'd6:  op = wop(A_TMD, INIT_MD);
                4'd7:  op = wop(A_TLO, '0);
                4'd8:  op = wop(A_TCNT, TCNT_VAL);
                4'd9:  op = wop(A_ZACT, ZACT_VAL);
                4'd10: op = wop(A_ICLR, DW'(ZEN_BOTH));
                4'd11: op = wop(A_GCLR, DW'(1));
                4'd12: op = wop(A_GEN, DW'(1));
                4'd13: op = wop(A_IEN, DW'(ZEN_BOTH));
                default: op = wop(A_MEN, DW'(1));
            endcase
            S_RDST: op = rop(A_ISTAT);
            S_OFF: case (step)
                4'd0:    op = wop(A_GEN, '0);
                4'd1:    op = wop(A_IEN, '0);
                default: op = wop(A_MEN, '0);
            endcase
            S_RDPK: op = rop(A_ZMAX0 + (zone3 ? AW'(3) : AW'(1)));
            S_ARM: case (step)
                4'd0:    op = wop(A_THI, plan.thr_hi);
                4'd1:    op = wop(A_TMD, plan.thr_md);
                4'd2:    op = wop(A_CCLR, DW'(1));
                4'd3:    op = wop(A_ICLR, DW'(ZEN_BOTH));
                4'd4:    op = wop(A_GCLR, DW'(1));
                4'd5:    op = wop(A_GEN, DW'(1));
                4'd6:    op = wop(A_IEN, DW'(plan.zen));
                default: op = wop(A_MEN, DW'(1));
            endcase
            default: op = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_RST;
            step    <= '0;
            zone3   <= 1'b0;
            peak    <= '0;
            lvl_idx <= '0;
            have    <= 1'b0;
            lvl_vld <= 1'b0;
        end else begin
            lvl_vld <= 1'b0;
            case (st)
                S_RST:  begin st <= S_INIT; step <= '0; end
                S_INIT: if (step == 4'(INIT_N - 1)) begin st <= S_IDLE; step <= '0; end
                        else step <= step + 4'd1;
                S_IDLE: if (irq) st <= S_RDST;
                S_RDST: st <= S_WTST;
                S_WTST: if ((rdata[7:0] & ZEN_BOTH) == 8'h00) st <= S_IDLE;
                        else begin
                            zone3 <= rdata[ST_ZONE_LSB + 3];
                            st    <= S_OFF;
                            step  <= '0;
                        end
                S_OFF:  if (step == 4'(OFF_N - 1)) begin st <= S_RDPK; step <= '0; end
                        else step <= step + 4'd1;
                S_RDPK: st <= S_WTPK;
                S_WTPK: begin peak <= rdata; st <= S_ARM; step <= '0; end
                S_ARM:  if (step == 4'(ARM_N - 1)) begin
                            st   <= S_IDLE;
                            step <= '0;
                            if (!have || plan.idx != lvl_idx) begin
                                lvl_idx <= plan.idx;
                                have    <= 1'b1;
                                lvl_vld <= 1'b1;
                            end
                        end else step <= step + 4'd1;
                default: st <= S_RST;
            endcase
        end
    end

    assign busy = (st != S_IDLE) && (st != S_RST);

    assert_single_read_R3: assert property (@(posedge clk) disable iff (rst)
        (op.en && !op.wr) |=> !op.en);
    assert_bus_only_busy_R11: assert property (@(posedge clk) disable iff (rst)
        op.en |-> busy);
    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        lvl_vld |=> !lvl_vld);
    assert_no_repeat_R10: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARM && step == 4'(ARM_N - 1) && have && plan.idx == lvl_idx) |=> !lvl_vld);
    assert_enable_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (op.en && op.wr && op.addr == A_IEN) |-> ((op.data & ~DW'(ZEN_BOTH)) == '0));
endmodule

// File: rtl/bw_governor.sv
module bw_governor
    import bwg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    output logic          rg_en,
    output logic          rg_wr,
    output logic [AW-1:0] rg_addr,
    output logic [DW-1:0] rg_wdata,
    input  logic [DW-1:0] rg_rdata,
    output logic [LW-1:0] lvl_idx,
    output logic          lvl_vld,
    output logic          busy
);
    plan_t         plan;
    bus_op_t       op;
    logic [DW-1:0] peak;

    bwg_calc u_calc (
        .clk  (clk),
        .rst  (rst),
        .peak (peak),
        .plan (plan)
    );

    bwg_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq),
        .rdata   (rg_rdata),
        .plan    (plan),
        .peak    (peak),
        .op      (op),
        .lvl_idx (lvl_idx),
        .lvl_vld (lvl_vld),
        .busy    (busy)
    );

    assign rg_en    = op.en;
    assign rg_wr    = op.wr;
    assign rg_addr  = op.addr;
    assign rg_wdata = op.data;
endmodule

// File: tb/sim_bw_governor.sv
module sim_bw_governor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic        rg_en, rg_wr, lvl_vld, busy;
    logic [5:0]  rg_addr;
    logic [31:0] rg_wdata;
    logic [31:0] rg_rdata = '0;
    logic [2:0]  lvl_idx;

    always #2 clk = ~clk;

    bw_governor u0 (
        .clk(clk), .rst(rst), .irq(irq),
        .rg_en(rg_en), .rg_wr(rg_wr), .rg_addr(rg_addr), .rg_wdata(rg_wdata),
        .rg_rdata(rg_rdata), .lvl_idx(lvl_idx), .lvl_vld(lvl_vld), .busy(busy)
    );

    logic [31:0] mon [64];
    int          checks = 0;
    int          fails = 0;
    logic [38:0] eq[$];
    string       tq[$];
    int          lq[$];
    bit          have = 0;
    int          cur = 0;
    int          cyc = 0;

    always @(posedge clk) if (rg_en && !rg_wr) rg_rdata <= mon[rg_addr];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit wr, input int a, input longint d, input string tag);
        eq.push_back({wr, 6'(a), 32'(d)});
        tq.push_back(tag);
    endtask

    function automatic longint kb(input int i);
        case (i)
            0: return 4800000;
            1: return 9216000;
            2: return 15052800;
            3: return 20889600;
            default: return 25497600;
        endcase
    endfunction

    function automatic longint thr(input longint k);
        return ((k / 64) * 4) / 1000;
    endfunction

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (rg_en) begin
                if (eq.size() == 0)
                    chk(0, "R9", "unexpected bus op", {25'd0, rg_wr, rg_addr, rg_wdata}, 0);
                else begin
                    logic [38:0] e;
                    string t;
                    e = eq.pop_front();
                    t = tq.pop_front();
                    chk({rg_wr, rg_addr, rg_wdata} == e, t, "bus op",
                        {25'd0, rg_wr, rg_addr, rg_wdata}, {25'd0, e});
                end
            end
            if (lvl_vld) begin
                if (lq.size() == 0)
                    chk(0, "R10", "unexpected level strobe", 64'(lvl_idx), 0);
                else begin
                    int x;
                    x = lq.pop_front();
                    chk(lvl_idx == 3'(x), "R10", "level index", 64'(lvl_idx), 64'(x));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic service(input logic [31:0] st, input logic [31:0] pk1,
                           input logic [31:0] pk3, input bit poke);
        mon[8'h08] = st;
        mon[8'h19] = pk1;
        mon[8'h1B] = pk3;
        push(0, 8'h08, 0, "R2");
        if ((st & 32'hA0) != 0) begin
            bit     z3;
            longint pk, meas;
            int     t;
            z3 = st[7];
            push(1, 8'h01, 0, "R4");
            push(1, 8'h0A, 0, "R4");
            push(1, 8'h10, 0, "R4");
            push(0, z3 ? 8'h1B : 8'h19, 0, "R3");
            pk = z3 ? longint'(pk3) : longint'(pk1);
            meas = (pk + 1) * 64 * 1000 / 4;
            t = 4;
            for (int i = 4; i >= 0; i--) if (kb(i) >= meas) t = i;
            push(1, 8'h13, thr(kb(t) + 1), "R6");
            push(1, 8'h14, thr(t == 0 ? kb(0) : kb(t - 1)), "R7");
            push(1, 8'h11, 1, "R9");
            push(1, 8'h09, 8'hA0, "R9");
            push(1, 8'h02, 1, "R9");
            push(1, 8'h01, 1, "R9");
            push(1, 8'h0A, (t == 4) ? 8'h20 : (t == 0) ? 8'h80 : 8'hA0, "R8");
            push(1, 8'h10, 1, "R9");
            if (!have || t != cur) lq.push_back(t);   // R5 target, R10 change
            have = 1;
            cur = t;
        end
        @(negedge clk) irq = 1'b1;
        @(negedge clk) irq = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            irq = 1'b1;                              // R11 pulse while busy
            @(negedge clk) irq = 1'b0;
        end
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(eq.size() == 0, poke ? "R11" : "R9", "bus ops outstanding", 64'(eq.size()), 0);
        chk(lq.size() == 0, "R10", "level strobes outstanding", 64'(lq.size()), 0);
        eq.delete();
        tq.delete();
        lq.delete();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mon[i] = '0;
        repeat (3) @(negedge clk);
        chk(rg_en == 1'b0, "R1", "bus idle in reset", 64'(rg_en), 0);
        chk(lvl_vld == 1'b0, "R1", "no strobe in reset", 64'(lvl_vld), 0);
        // R1 start-up programming
        push(1, 8'h01, 0, "R1");        push(1, 8'h0A, 0, "R1");
        push(1, 8'h10, 0, "R1");        push(1, 8'h11, 1, "R1");
        push(1, 8'h12, 76800, "R1");    push(1, 8'h13, 307, "R1");
        push(1, 8'h14, 32, "R1");       push(1, 8'h15, 0, "R1");
        push(1, 8'h16, 32'h01FF10FF, "R1");
        push(1, 8'h17, 32'h95250901, "R1");
        push(1, 8'h09, 8'hA0, "R1");    push(1, 8'h02, 1, "R1");
        push(1, 8'h01, 1, "R1");        push(1, 8'h0A, 8'hA0, "R1");
        push(1, 8'h10, 1, "R1");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(eq.size() == 0, "R1", "start-up ops outstanding", 64'(eq.size()), 0);

        service(32'h40, 0, 0, 0);         // R2 zone 2 only: ignored
        service(32'h80, 0, 312, 0);       // R5 -> level 1
        service(32'h20, 0, 0, 0);         // R8 -> level 0, zone 3 only
        service(32'h80, 0, 5000, 0);      // R5 saturate -> level 4
        service(32'h80, 0, 4000, 1);      // R10 same level, R11 busy pulse
        service(32'hA0, 0, 1250, 0);      // R3 both set -> zone 3, level 3
        service(32'h20, 299, 0, 0);       // R5 exact boundary -> level 0
        service(32'h20, 300, 0, 0);       // R5 just above -> level 1
        service(32'h50, 0, 0, 0);         // R2 zones 0 and 2: ignored
        chk(lvl_idx == 3'd1, "R10", "held level after ignored event", 64'(lvl_idx), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule